// File: doc/BRIEF.md
# Cache Tag Store with Wired-AND Hit Flag

This block stores one tag per cache line, indexed by the low line-select bits of a processor address, and tells the cache controller whether the tag presented on the data port equals the stored tag at that index. The full build holds 8192 tags of 8 bits each (`IDX_W` = 13). With that setting, 8K lines are placed into a 1 MB space: the 13 line bits index the store and the 7 page bits, plus one spare bit, form the tag. The default `IDX_W` is smaller so that the default elaboration stays compact. The index width, tag width and device count are all parameters.

Each device in the array has its own active-low chip enable. Index, data, write enable, output enable and the clear command are shared. A selected device reads, writes or compares, depending on the active-low write and output enables. The hit flag of a device is forced high whenever it is not comparing, so the flags of all devices can be ANDed into one shared line. The top level models that open-drain sharing as a logical AND.

An active-low clear command wipes every entry to zero. It does this with a sweep that writes one entry per clock and shows its progress on a busy output. Reads, writes, compares and further clear commands are ignored until the sweep ends.

Top module: `ctag_array`

## Requirements
- R1: A selected device with `we_n`=0 writes `wdata` into entry `addr` at the clock edge.
- R2: A selected device with `we_n`=1 and `oe_n`=0 performs a read. After the edge, its lane of `rdata` (bits `[d*TAG_W +: TAG_W]` for device d) holds the stored word and `rd_vld[d]`=1. In every other cycle, `rd_vld[d]`=0.
- R3: A selected device with `we_n`=1 and `oe_n`=1 is in compare mode. After the edge, its flag is 1 if `wdata` equals entry `addr` and 0 otherwise.
- R4: A compare in the cycle right after a write to the same entry sees the newly written word.
- R5: The flag of a device is 1 after any edge at which that device was not comparing. This covers `we_n`=0 and `oe_n`=0.
- R6: A device with `ce_n[d]`=1 is in standby. It performs no access, gives `rd_vld[d]`=0, and contributes a flag of 1.
- R7: When `clr_n` is sampled low while idle, `clr_busy` rises after that edge and stays high for 2^IDX_W cycles. Afterwards, every entry of every device reads as zero.
- R8: While `clr_n` is low or `clr_busy` is high, writes and reads are ignored. Entries keep the clear result and `rd_vld` stays 0.
- R9: `match` is 1 after every edge at which `clr_n` was low or `clr_busy` was high.
- R10: `match` is the AND of all device flags. A single comparing device that misses pulls it to 0.
- R11: While `rst_n` is low, and until the first sampled command after its release, `match`=1, `rd_vld`=0 and `clr_busy`=0. Release takes effect on the second clock edge after `rst_n` rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| clr_n | input | 1 | Active-low command to wipe all entries |
| ce_n | input | N_DEV | Active-low chip enable, one bit per device |
| we_n | input | 1 | Active-low write enable (shared) |
| oe_n | input | 1 | Active-low output enable (shared) |
| addr | input | IDX_W | Line index (shared) |
| wdata | input | TAG_W | Data port: write word or compare probe |
| rdata | output | N_DEV*TAG_W | Read word, one lane per device |
| rd_vld | output | N_DEV | Read word valid, one bit per device |
| match | output | 1 | Wired-AND hit flag of all devices |
| clr_busy | output | 1 | Clear sweep in progress |

## Verification
A corrupted entry shows up at `rdata` or `match` on the first read or compare of that index. It appears one cycle after the command, so the bench drives reads and compares over written, overwritten and cleared indices. A sweep counter that stops early or wraps wrongly leaves stale entries, or changes the length of `clr_busy`. Both are caught the cycle the busy flag differs from the model, or when the post-clear readback reaches the missed index. A decode fault in the mode logic appears as a flag that is 0 outside compare mode, or as a spurious `rd_vld`, on the very next edge.

// File: rtl/ctag_pkg.sv
package ctag_pkg;
  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2,
    OP_CMP   = 2'd3
  } op_e;
endpackage

// File: rtl/ctag_rst_sync.sv
module ctag_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign srst_n = sync_q[1];
endmodule

// File: rtl/ctag_mem.sv
module ctag_mem #(
  parameter int IDX_W = 10,
  parameter int TAG_W = 8
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_addr,
  input  logic [TAG_W-1:0] wr_data,
  input  logic [IDX_W-1:0] rd_addr,
  output logic [TAG_W-1:0] rd_word
);
  localparam int DEPTH = 1 << IDX_W;

  logic [TAG_W-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) store[wr_addr] <= wr_data;
  end

  assign rd_word = store[rd_addr];
endmodule

// File: rtl/ctag_sweep.sv
module ctag_sweep #(
  parameter int IDX_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_n,
  output logic             busy,
  output logic             sweep_we,
  output logic [IDX_W-1:0] sweep_addr
);
  localparam logic [IDX_W-1:0] LAST = {IDX_W{1'b1}};

  logic             busy_q, busy_d;
  logic [IDX_W-1:0] cnt_q, cnt_d;

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    if (busy_q) begin
      cnt_d = cnt_q + 1'b1;
      if (cnt_q == LAST) busy_d = 1'b0;
    end else if (!clr_n) begin
      busy_d = 1'b1;
      cnt_d  = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
    end
  end

  assign busy       = busy_q;
  assign sweep_we   = busy_q;
  assign sweep_addr = cnt_q;
endmodule

// File: rtl/ctag_ctrl.sv
module ctag_ctrl
  import ctag_pkg::*;
#(
  parameter int TAG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hold,
  input  logic             ce_n,
  input  logic             we_n,
  input  logic             oe_n,
  input  logic [TAG_W-1:0] probe,
  input  logic [TAG_W-1:0] stored,
  output op_e              op,
  output logic             hit,
  output logic [TAG_W-1:0] rword,
  output logic             rvld
);
  op_e              op_d;
  logic             hit_d, rvld_d, rword_en;
  logic             hit_q, rvld_q;
  logic [TAG_W-1:0] rword_q;
  logic [TAG_W-1:0] diff;

  // Mode decode; a running clear masks every command.
  always_comb begin
    op_d = OP_IDLE;
    if (!hold && !ce_n) begin
      if (!we_n)      op_d = OP_WRITE;
      else if (!oe_n) op_d = OP_READ;
      else            op_d = OP_CMP;
    end
  end

  assign diff = probe ^ stored;

  always_comb begin
    hit_d    = 1'b1;
    rvld_d   = 1'b0;
    rword_en = 1'b0;
    unique case (op_d)
      OP_READ: begin
        rvld_d   = 1'b1;
        rword_en = 1'b1;
      end
      OP_CMP:  hit_d = ~|diff;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_q  <= 1'b1;
      rvld_q <= 1'b0;
    end else begin
      hit_q  <= hit_d;
      rvld_q <= rvld_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        rword_q <= '0;
    else if (rword_en) rword_q <= stored;
  end

  assign op    = op_d;
  assign hit   = hit_q;
  assign rword = rword_q;
  assign rvld  = rvld_q;
endmodule

// File: rtl/ctag_device.sv
module ctag_device
  import ctag_pkg::*;
#(
  parameter int IDX_W = 10,
  parameter int TAG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_n,
  input  logic             ce_n,
  input  logic             we_n,
  input  logic             oe_n,
  input  logic [IDX_W-1:0] addr,
  input  logic [TAG_W-1:0] wdata,
  output logic [TAG_W-1:0] rword,
  output logic             rvld,
  output logic             hit,
  output logic             busy
);
  op_e              op;
  logic             sweep_we;
  logic [IDX_W-1:0] sweep_addr;
  logic             mem_we;
  logic [IDX_W-1:0] mem_waddr;
  logic [TAG_W-1:0] mem_wdata;
  logic [TAG_W-1:0] stored;
  logic             hold;

  ctag_sweep #(.IDX_W(IDX_W)) u_sweep (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr_n      (clr_n),
    .busy       (busy),
    .sweep_we   (sweep_we),
    .sweep_addr (sweep_addr)
  );

  assign hold = busy | ~clr_n;

  ctag_ctrl #(.TAG_W(TAG_W)) u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .hold   (hold),
    .ce_n   (ce_n),
    .we_n   (we_n),
    .oe_n   (oe_n),
    .probe  (wdata),
    .stored (stored),
    .op     (op),
    .hit    (hit),
    .rword  (rword),
    .rvld   (rvld)
  );

  // Sweep owns the write port while busy; the user write is masked by hold.
  assign mem_we    = sweep_we | (op == OP_WRITE);
  assign mem_waddr = sweep_we ? sweep_addr : addr;
  assign mem_wdata = sweep_we ? '0 : wdata;

  ctag_mem #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_mem (
    .clk     (clk),
    .wr_en   (mem_we),
    .wr_addr (mem_waddr),
    .wr_data (mem_wdata),
    .rd_addr (addr),
    .rd_word (stored)
  );
endmodule

// File: rtl/ctag_array.sv
module ctag_array #(
  parameter int N_DEV = 2,
  parameter int IDX_W = 10,
  parameter int TAG_W = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   clr_n,
  input  logic [N_DEV-1:0]       ce_n,
  input  logic                   we_n,
  input  logic                   oe_n,
  input  logic [IDX_W-1:0]       addr,
  input  logic [TAG_W-1:0]       wdata,
  output logic [N_DEV*TAG_W-1:0] rdata,
  output logic [N_DEV-1:0]       rd_vld,
  output logic                   match,
  output logic                   clr_busy
);
  logic             srst_n;
  logic [N_DEV-1:0] dev_hit;
  logic [N_DEV-1:0] dev_busy;

  ctag_rst_sync u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  for (genvar d = 0; d < N_DEV; d++) begin : g_dev
    ctag_device #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_dev (
      .clk   (clk),
      .rst_n (srst_n),
      .clr_n (clr_n),
      .ce_n  (ce_n[d]),
      .we_n  (we_n),
      .oe_n  (oe_n),
      .addr  (addr),
      .wdata (wdata),
      .rword (rdata[d*TAG_W +: TAG_W]),
      .rvld  (rd_vld[d]),
      .hit   (dev_hit[d]),
      .busy  (dev_busy[d])
    );
  end

  // Open-drain sharing modelled as AND of every device flag.
  assign match    = &dev_hit;
  assign clr_busy = |dev_busy;
endmodule

// File: rtl/ctag_array_chk.sv
module ctag_array_chk #(
  parameter int N_DEV = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             clr_n,
  input logic [N_DEV-1:0] ce_n,
  input logic             we_n,
  input logic             oe_n,
  input logic [N_DEV-1:0] rd_vld,
  input logic             match,
  input logic             clr_busy
);
  // R5
  write_keeps_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(we_n) |-> match);

  // R5
  outen_keeps_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(oe_n) |-> match);

  // R6
  standby_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(&ce_n) |-> (match && (rd_vld == '0)));

  // R9
  clear_keeps_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(clr_n) || $past(clr_busy)) |-> match);

  // R8
  clear_blocks_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_busy || !clr_n) |=> (rd_vld == '0));

  // R7
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clr_busy) |-> !$past(clr_n));

  // R2
  read_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_vld != '0) |-> ($past(we_n) && !$past(oe_n)));
endmodule

bind ctag_array ctag_array_chk #(.N_DEV(N_DEV)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .clr_n    (clr_n),
  .ce_n     (ce_n),
  .we_n     (we_n),
  .oe_n     (oe_n),
  .rd_vld   (rd_vld),
  .match    (match),
  .clr_busy (clr_busy)
);

// File: tb/sim_ctag_array.sv
`timescale 1ns/100ps
module sim_ctag_array;
  localparam int N     = 2;
  localparam int IW    = 6;
  localparam int TW    = 8;
  localparam int DEPTH = 1 << IW;

  logic            clk;
  logic            rst_n;
  logic            clr_n;
  logic [N-1:0]    ce_n;
  logic            we_n;
  logic            oe_n;
  logic [IW-1:0]   addr;
  logic [TW-1:0]   wdata;
  logic [N*TW-1:0] rdata;
  logic [N-1:0]    rd_vld;
  logic            match;
  logic            clr_busy;

  ctag_array #(.N_DEV(N), .IDX_W(IW), .TAG_W(TW)) u0 (
    .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .ce_n(ce_n), .we_n(we_n),
    .oe_n(oe_n), .addr(addr), .wdata(wdata), .rdata(rdata),
    .rd_vld(rd_vld), .match(match), .clr_busy(clr_busy)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int    n_chk;
  int    n_bad;
  string tag;
  bit    chk_on;

  // Behavioural reference model
  logic [TW-1:0] shadow [N][DEPTH];
  logic [TW-1:0] exp_rd [N];
  logic [N-1:0]  exp_vld;
  logic          exp_match;
  logic          exp_busy;
  int            busy_left;

  always @(posedge clk) begin
    if (!rst_n) begin
      exp_match = 1'b1;
      exp_vld   = '0;
      exp_busy  = 1'b0;
      busy_left = 0;
    end else if (busy_left > 0) begin
      for (int d = 0; d < N; d++) shadow[d][DEPTH - busy_left] = '0;
      busy_left = busy_left - 1;
      exp_busy  = (busy_left != 0);
      exp_match = 1'b1;
      exp_vld   = '0;
    end else if (!clr_n) begin
      busy_left = DEPTH;
      exp_busy  = 1'b1;
      exp_match = 1'b1;
      exp_vld   = '0;
    end else begin
      exp_match = 1'b1;
      for (int d = 0; d < N; d++) begin
        exp_vld[d] = 1'b0;
        if (!ce_n[d]) begin
          if (!we_n) shadow[d][addr] = wdata;
          else if (!oe_n) begin
            exp_rd[d]  = shadow[d][addr];
            exp_vld[d] = 1'b1;
          end else if (shadow[d][addr] != wdata) exp_match = 1'b0;
        end
      end
    end
  end

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string what);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (chk_on) begin
      check({31'd0, match}, {31'd0, exp_match}, "match");
      check({31'd0, clr_busy}, {31'd0, exp_busy}, "clr_busy");
      check({30'd0, rd_vld}, {30'd0, exp_vld}, "rd_vld");
      for (int d = 0; d < N; d++)
        if (exp_vld[d]) check({24'd0, rdata[d*TW +: TW]}, {24'd0, exp_rd[d]}, "rdata");
    end
  end

  task automatic drive(input logic [N-1:0] c, input logic w, input logic o,
                       input logic cl, input int a, input logic [TW-1:0] dat);
    @(negedge clk);
    ce_n  = c;
    we_n  = w;
    oe_n  = o;
    clr_n = cl;
    addr  = a[IW-1:0];
    wdata = dat;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(2'b11, 1'b1, 1'b1, 1'b1, 0, 8'h00);
  endtask

  task automatic finish_run;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #500000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    n_chk = 0; n_bad = 0; chk_on = 1'b0; tag = "R11";
    rst_n = 1'b0; clr_n = 1'b1; ce_n = 2'b11; we_n = 1'b1; oe_n = 1'b1;
    addr = '0; wdata = '0;
    repeat (3) @(posedge clk);
    chk_on = 1'b1;
    idle(2);
    rst_n = 1'b1;
    idle(4);

    // R7: sweep from unknown contents, with blocked traffic on top
    tag = "R7";
    drive(2'b11, 1'b1, 1'b1, 1'b0, 0, 8'h00);
    tag = "R8";
    for (int i = 0; i < 8; i++) drive(2'b00, 1'b0, 1'b1, 1'b1, 5, 8'hAA);
    for (int i = 0; i < 8; i++) drive(2'b00, 1'b1, 1'b0, 1'b1, 5, 8'h00);
    tag = "R9";
    for (int i = 0; i < 8; i++) drive(2'b00, 1'b1, 1'b1, 1'b1, 5, 8'h11);
    tag = "R7";
    idle(DEPTH - 24 + 3);
    tag = "R8";
    drive(2'b00, 1'b1, 1'b0, 1'b1, 5, 8'h00);
    idle(1);

    tag = "R1";
    for (int i = 0; i < 16; i++) drive(2'b10, 1'b0, 1'b1, 1'b1, i, 8'($urandom));
    for (int i = 0; i < 16; i++) drive(2'b01, 1'b0, 1'b1, 1'b1, i, 8'($urandom));
    drive(2'b10, 1'b0, 1'b1, 1'b1, 3, 8'hE7);
    tag = "R2";
    for (int i = 0; i < 16; i++) drive(2'b00, 1'b1, 1'b0, 1'b1, i, 8'h00);
    drive(2'b10, 1'b1, 1'b0, 1'b1, 3, 8'h00);

    tag = "R3";
    for (int i = 0; i < 16; i++) drive(2'b10, 1'b1, 1'b1, 1'b1, i, shadow[0][i]);
    for (int i = 0; i < 16; i++) drive(2'b01, 1'b1, 1'b1, 1'b1, i, shadow[1][i] ^ 8'h01);
    drive(2'b10, 1'b1, 1'b1, 1'b1, 3, 8'hE7);
    drive(2'b10, 1'b1, 1'b1, 1'b1, 3, 8'h67);

    tag = "R4";
    drive(2'b10, 1'b0, 1'b1, 1'b1, 30, 8'h5C);
    drive(2'b10, 1'b1, 1'b1, 1'b1, 30, 8'h5C);
    drive(2'b10, 1'b0, 1'b1, 1'b1, 30, 8'hC5);
    drive(2'b10, 1'b1, 1'b1, 1'b1, 30, 8'h5C);
    drive(2'b10, 1'b1, 1'b1, 1'b1, 30, 8'hC5);

    tag = "R5";
    drive(2'b00, 1'b1, 1'b0, 1'b1, 30, 8'hFF);
    drive(2'b00, 1'b0, 1'b0, 1'b1, 31, 8'h3A);
    drive(2'b00, 1'b0, 1'b1, 1'b1, 32, 8'h3B);
    drive(2'b00, 1'b1, 1'b1, 1'b1, 31, 8'h3A);

    tag = "R6";
    for (int i = 0; i < 6; i++) drive(2'b11, 1'b1, 1'b1, 1'b1, i, 8'hFF);
    drive(2'b11, 1'b0, 1'b1, 1'b1, 3, 8'h00);
    drive(2'b11, 1'b1, 1'b0, 1'b1, 3, 8'h00);
    drive(2'b10, 1'b1, 1'b1, 1'b1, 3, 8'hE7);

    tag = "R10";
    drive(2'b00, 1'b0, 1'b1, 1'b1, 40, 8'h9D);
    drive(2'b10, 1'b0, 1'b1, 1'b1, 41, 8'h42);
    drive(2'b01, 1'b0, 1'b1, 1'b1, 41, 8'h24);
    drive(2'b00, 1'b1, 1'b1, 1'b1, 40, 8'h9D);
    drive(2'b00, 1'b1, 1'b1, 1'b1, 41, 8'h42);
    drive(2'b10, 1'b1, 1'b1, 1'b1, 41, 8'h42);
    drive(2'b01, 1'b1, 1'b1, 1'b1, 41, 8'h42);
    drive(2'b01, 1'b1, 1'b1, 1'b1, 41, 8'h24);

    tag = "R7";
    drive(2'b11, 1'b1, 1'b1, 1'b0, 0, 8'h00);
    idle(DEPTH + 2);
    for (int i = 0; i < DEPTH; i++) drive(2'b00, 1'b1, 1'b0, 1'b1, i, 8'h00);
    tag = "R9";
    drive(2'b00, 1'b1, 1'b1, 1'b1, 40, 8'h00);
    idle(3);

    tag = "R11";
    rst_n = 1'b0;
    idle(3);
    rst_n = 1'b1;
    idle(4);
    chk_on = 1'b0;
    finish_run();
  end
endmodule